// File: doc/BRIEF.md
# Three-in-a-Row Serial Ones Detector

This block watches a one-bit serial stream that is sampled on every rising clock edge. It raises a one-bit flag when the bit now on the input is the third one in an unbroken run. A small counter register tracks progress through the run. A zero resets that progress, and so does a completed match.

The flag is combinational from the stored count and the live input bit, so it is valid in the same cycle as the completing bit. A consumer samples it on the rising edge that captures that bit.

Matches do not overlap. A completed run returns the counter to idle, so the fourth and fifth ones of a long run start a new run, and the sixth one completes it. The run length is a parameter and defaults to three.

Top module: `ones_run_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the run counter is cleared. Reset wins over any input value, so ones presented during reset never count toward a match, and `detect` stays 0 during reset.
- R2: A 0 on `din` breaks the run. For example, the stream 1,1,0,1 raises no match, and two further ones after the last 1 are then needed.
- R3: When two consecutive ones have been captured and `din` is 1, `detect` is 1 in that same cycle, before the edge that captures the third one.
- R4: `detect` is 0 whenever `din` is 0, including when two ones have already been captured.
- R5: Detection is non-overlapping. After a match, the next one on `din` counts as the first of a new run. In a run of six ones, `detect` is 1 only on the 3rd and 6th, and a run of four or five ones gives a single match.
- R6: `detect` is never 1 in two consecutive cycles.
- R7: For any bit stream, `detect` equals a model that counts consecutive ones and clears the count on a 0 or on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, one per cycle |
| detect | output | 1 | High when the current bit completes a run of ones |

## Verification
The hard case is the boundary inside a long run of ones, where the machine must restart instead of staying in a matched state. A stream that matches every cycle once three ones are seen still looks plausible, so directed runs of four, five and six ones are placed in the vector table with the exact cycle of each expected match. Ones held on the input through reset are used to show that reset overrides the next-state value. A long stream of random bits, biased toward ones, then reaches many more run boundaries than the directed patterns do.

// File: rtl/ones_det_pkg.sv
package ones_det_pkg;
  function automatic int cnt_width(input int run_len);
    return (run_len <= 2) ? 1 : $clog2(run_len);
  endfunction
endpackage

// File: rtl/ones_det_next.sv
module ones_det_next #(
  parameter int MATCH_LEN = 3,
  parameter int CW        = 2
) (
  input  logic [CW-1:0] cur,
  input  logic          din,
  output logic [CW-1:0] nxt,
  output logic          hit
);
  localparam logic [CW-1:0] LAST = CW'(MATCH_LEN - 1);

  always_comb begin
    nxt = '0;
    hit = 1'b0;
    if (din && (cur < LAST)) begin
      nxt = cur + CW'(1);
    end else if (din && (cur == LAST)) begin
      hit = 1'b1;
    end
    // a zero input, or an unused code above LAST, falls back to idle
  end
endmodule

// File: rtl/ones_det_state.sv
module ones_det_state #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] nxt,
  output logic [CW-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end
endmodule

// File: rtl/ones_run_detector.sv
module ones_run_detector #(
  parameter int MATCH_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic detect
);
  import ones_det_pkg::*;
  localparam int CW = cnt_width(MATCH_LEN);

  logic [CW-1:0] cur_state;
  logic [CW-1:0] nxt_state;
  logic          hit;

  ones_det_state #(.CW(CW)) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_state),
    .cur (cur_state)
  );

  ones_det_next #(.MATCH_LEN(MATCH_LEN), .CW(CW)) u_next (
    .cur (cur_state),
    .din (din),
    .nxt (nxt_state),
    .hit (hit)
  );

  assign detect = hit;
endmodule

// File: rtl/ones_run_checker.sv
module ones_run_checker #(
  parameter int MATCH_LEN = 3,
  parameter int CW        = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          din,
  input logic          detect,
  input logic [CW-1:0] state
);
  localparam logic [CW-1:0] LAST = CW'(MATCH_LEN - 1);

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == '0));

  a_r2_zero_breaks_run: assert property (@(posedge clk) disable iff (rst)
    !din |=> (state == '0));

  a_r3_third_one_flags: assert property (@(posedge clk) disable iff (rst)
    (state == LAST && din) |-> detect);

  a_r4_no_flag_on_zero: assert property (@(posedge clk) disable iff (rst)
    detect |-> din);

  a_r5_restart_after_match: assert property (@(posedge clk) disable iff (rst)
    detect |=> (state == '0));

  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    detect |=> !detect);
endmodule

bind ones_run_detector ones_run_checker #(.MATCH_LEN(MATCH_LEN), .CW(CW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .din    (din),
  .detect (detect),
  .state  (cur_state)
);

// File: tb/ones_run_detector_bench.sv
module ones_run_detector_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic detect;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  ones_run_detector u_ones_run_detector (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .detect (detect)
  );

  localparam int NV = 20;
  // runs of six, two, three and four ones, with isolated ones between them
  localparam bit VIN  [NV] = '{1,1,1,1,1,1,0,1,1,0,1,1,1,0,1,0,1,1,1,1};
  localparam bit VEXP [NV] = '{0,0,1,0,0,1,0,0,0,0,0,0,1,0,0,0,0,0,1,0};

  task automatic step(input logic b, input logic exp, input string tag);
    @(posedge clk);
    #1 din = b;
    @(negedge clk);
    checks++;
    if (detect !== exp) begin
      errors++;
      $display("FAIL %s: detect=%b expected=%b", tag, detect, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic b, e;
    repeat (3) @(posedge clk);
    // R1: reset state, with a one on the input
    step(1'b1, 1'b0, "R1 reset state");
    #1 rst = 1'b0;
    din = 1'b0;
    // vector table covers R3, R5 and R2
    for (int i = 0; i < NV; i++)
      step(VIN[i], VEXP[i], "R3/R5/R2 vector table");
    // R1: ones held through reset must not count
    @(posedge clk); #1 rst = 1'b1;
    step(1'b1, 1'b0, "R1 ones during reset");
    step(1'b1, 1'b0, "R1 ones during reset");
    step(1'b1, 1'b0, "R1 ones during reset");
    @(posedge clk); #1 rst = 1'b0;
    // the edge above was still under reset; now three fresh ones are needed
    @(negedge clk);
    checks++;
    if (detect !== 1'b0) begin
      errors++;
      $display("FAIL R1 first bit after reset: detect=%b expected=0", detect);
    end
    step(1'b1, 1'b0, "R1 run restarts after reset");
    step(1'b1, 1'b1, "R1 run restarts after reset");
    // R4: two ones captured then a zero
    step(1'b1, 1'b0, "R4 setup");
    step(1'b1, 1'b0, "R4 setup");
    step(1'b0, 1'b0, "R4 zero after two ones");
    // R2: 1,1,0,1 then two more ones
    step(1'b1, 1'b0, "R2 break");
    step(1'b1, 1'b0, "R2 break");
    step(1'b0, 1'b0, "R2 break");
    step(1'b1, 1'b0, "R2 after break");
    step(1'b1, 1'b0, "R2 after break");
    step(1'b1, 1'b1, "R2 third one after break");
    // R5: a run of five ones gives exactly one match
    step(1'b0, 1'b0, "R5 gap");
    step(1'b1, 1'b0, "R5 five run");
    step(1'b1, 1'b0, "R5 five run");
    step(1'b1, 1'b1, "R5 five run");
    step(1'b1, 1'b0, "R5 five run");
    step(1'b1, 1'b0, "R5 five run");
    step(1'b0, 1'b0, "R5 five run end");
    // R7 and R6: random stream against the model
    cnt = 0;
    for (int k = 0; k < 4000; k++) begin
      b = (($urandom % 4) != 0);
      e = b && (cnt == 2);
      step(b, e, "R7 random model");
      if (!b || e) cnt = 0;
      else         cnt = cnt + 1;
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // R6: the bench also watches for two flagged cycles in a row
  logic prev_det = 1'b0;
  always @(negedge clk) begin
    if (!rst && prev_det === 1'b1 && detect === 1'b1) begin
      checks++;
      errors++;
      $display("FAIL R6 back-to-back: detect=1 expected=0");
    end
    prev_det <= rst ? 1'b0 : detect;
  end
endmodule